// File: doc/BRIEF.md
# System Clock Mode Controller

This block generates the CPU clock enable and a set of peripheral clock enables from a fast main clock and a slow sub-clock. The sub-clock reaches the block as a one-cycle tick, already in the main clock domain. Two 8-bit control registers, written over a simple bus port, choose the CPU clock source and the main-clock divisor, and they control the low-power modes. A write reaches the registers only when both the bus strobe and a write-allow qualifier from a protection unit are high.

The CPU clock enable is either the main clock divided by 1, 2, 4, 8 or 16, or the sub-clock tick. The peripheral strobes are the main clock divided by 1, 8 and 32, an A-D clock, and the sub-clock divided by 32. A wait request halts the CPU clock and, if the control bit for it is set, the main-derived peripheral strobes as well. Writing the stop bit halts every enable. An enabled interrupt (the wake input) leaves either mode. On entry to stop mode, some control bits are set automatically, depending on whether the main clock or the sub-clock was driving the CPU.

Register 0 layout: bit7 sub-clock select, bit6 force divide-by-8, bit5 main clock off, bit4 sub-clock enable, bit3 sub-clock drive high, bit2 peripheral stop in wait, bits1:0 stored only. Register 1 layout: bits7:6 divisor select, bit5 main drive high, bits4:1 stored only, bit0 stop.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset, ctl0_o reads 0x48, ctl1_o reads 0x20, and wait_o is 0.
- R2: With register 0 bit6 = 1 and bit7 = 0, cpu_ce pulses once every 8 cycles, whatever register 1 bits7:6 hold.
- R3: With register 0 bits7:6 = 00, register 1 bits7:6 select the cpu_ce period: 00 gives 1 cycle, 01 gives 2, 10 gives 4, 11 gives 16.
- R4: A divisor change takes effect only when the current period ends. The cpu_ce gap that contains the write has the old length, and the gap after it has the new length.
- R5: A write with wr_allow_i = 0 leaves both registers unchanged.
- R6: A register 0 write that sets bit7 from 0 to 1 leaves bit7 at 0 unless register 0 bit4 was already 1 and sub_stable_i = 1. The other bits of that write are stored.
- R7: With bit7 = 1, cpu_ce equals sub_tick_i in every cycle. If bit5 = 1 as well, f1_ce, f8_ce, f32_ce and fad_ce stay 0.
- R8: Writing register 1 with bit0 = 1 while bit7 = 0 enters stop mode. Register 0 bits6 and 3 and register 1 bit5 are set to 1, and every enable output stays 0.
- R9: Entering stop mode while bit7 = 1 sets register 0 bit3 and leaves register 0 bit6 and register 1 bit5 unchanged.
- R10: A wake_i pulse clears register 1 bit0 and wait_o in the following cycle.
- R11: A wait_req_i pulse sets wait_o, and cpu_ce stays 0 while wait_o = 1. The main-derived peripheral strobes keep running if register 0 bit2 = 0 and stay 0 if bit2 = 1. fc32_ce keeps running in both cases.
- R12: While the main clock runs, f1_ce and fad_ce are high every cycle, f8_ce pulses every 8 cycles and f32_ce every 32 cycles. Every 32nd sub_tick_i raises fc32_ce. f32_ce implies f8_ce, and f8_ce implies f1_ce.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_tick_i | input | 1 | One-cycle sub-clock tick in the main clock domain |
| sub_stable_i | input | 1 | Sub-clock oscillation is stable |
| wr_en_i | input | 1 | Bus write strobe |
| wr_allow_i | input | 1 | Write-allow qualifier from the protection unit |
| wr_sel_i | input | 1 | Register select: 0 for register 0, 1 for register 1 |
| wr_data_i | input | 8 | Write data |
| wait_req_i | input | 1 | Request to enter wait mode |
| wake_i | input | 1 | Enabled interrupt; leaves wait or stop mode |
| ctl0_o | output | 8 | Register 0 contents |
| ctl1_o | output | 8 | Register 1 contents |
| wait_o | output | 1 | Wait mode active |
| cpu_ce | output | 1 | CPU clock enable |
| f1_ce | output | 1 | Main clock divided by 1 |
| f8_ce | output | 1 | Main clock divided by 8 |
| f32_ce | output | 1 | Main clock divided by 32 |
| fad_ce | output | 1 | A-D converter clock enable |
| fc32_ce | output | 1 | Sub-clock divided by 32 |

## Verification
The hardest case to reach is stop entry from low-speed mode, because the sub-clock select bit can only be set by a legal sequence. The stimulus first writes the enable bit, then raises sub_stable_i, then writes the select bit. Only then does it write the stop bit, and it checks that the drive and divide bits were left alone. A divisor change landing partway through a period is the other awkward case. The bench writes the new divisor a fixed number of cycles after a cpu_ce pulse, and checks that the gap containing the write still has the old length and the next gap has the new length.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  localparam int unsigned REG_W = 8;

  typedef struct packed {
    logic       sub_sel;
    logic       force8;
    logic       main_off;
    logic       sub_en;
    logic       sub_drv;
    logic       per_stop;
    logic [1:0] out_sel;
  } ctl0_t;

  typedef struct packed {
    logic [1:0] div_sel;
    logic       main_drv;
    logic [3:0] spare;
    logic       all_stop;
  } ctl1_t;

  localparam logic [REG_W-1:0] CTL0_RST = 8'h48;
  localparam logic [REG_W-1:0] CTL1_RST = 8'h20;
endpackage

// File: rtl/cmc_regs.sv
module cmc_regs
  import cmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             sub_stable,
  input  logic             wait_req,
  input  logic             wake,
  output ctl0_t            c0,
  output ctl1_t            c1,
  output logic             wait_q
);
  ctl0_t c0_n;
  ctl1_t c1_n;
  logic  wait_n;

  always_comb begin
    c0_n   = c0;
    c1_n   = c1;
    wait_n = wait_q;
    if (wr_stb && !wr_sel) begin
      c0_n = ctl0_t'(wr_data);
      if (!c0.sub_sel && c0_n.sub_sel && !(c0.sub_en && sub_stable))
        c0_n.sub_sel = 1'b0;
    end
    if (wr_stb && wr_sel) begin
      c1_n = ctl1_t'(wr_data);
      if (c1_n.all_stop && !c1.all_stop) begin
        c0_n.sub_drv = 1'b1;
        if (!c0.sub_sel) begin
          c0_n.force8  = 1'b1;
          c1_n.main_drv = 1'b1;
        end
      end
    end
    if (wait_req) wait_n = 1'b1;
    if (wake) begin
      wait_n        = 1'b0;
      c1_n.all_stop = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c0     <= ctl0_t'(CTL0_RST);
      c1     <= ctl1_t'(CTL1_RST);
      wait_q <= 1'b0;
    end else begin
      c0     <= c0_n;
      c1     <= c1_n;
      wait_q <= wait_n;
    end
  end
endmodule

// File: rtl/cmc_divider.sv
module cmc_divider #(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned RST_M1 = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] req_m1,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q, cnt_n, act_q, act_n;

  assign tick = run && (cnt_q == act_q);

  always_comb begin
    cnt_n = cnt_q;
    act_n = act_q;
    if (run) begin
      if (cnt_q == act_q) begin
        cnt_n = '0;
        act_n = req_m1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= CNT_W'(RST_M1);
    end else begin
      cnt_q <= cnt_n;
      act_q <= act_n;
    end
  end
endmodule

// File: rtl/cmc_prescale.sv
module cmc_prescale #(
  parameter int unsigned MAIN_LOG2 = 5,
  parameter int unsigned MID_LOG2  = 3,
  parameter int unsigned SUB_LOG2  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic per_run,
  input  logic sub_run,
  input  logic sub_tick,
  output logic f1,
  output logic fmid,
  output logic fmain,
  output logic fsub
);
  logic [MAIN_LOG2-1:0] mcnt_q;
  logic [SUB_LOG2-1:0]  scnt_q;

  assign f1    = per_run;
  assign fmid  = per_run && (&mcnt_q[MID_LOG2-1:0]);
  assign fmain = per_run && (&mcnt_q);
  assign fsub  = sub_run && sub_tick && (&scnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt_q <= '0;
      scnt_q <= '0;
    end else begin
      if (per_run) mcnt_q <= mcnt_q + 1'b1;
      if (sub_run && sub_tick) scnt_q <= scnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import cmc_pkg::*;
#(
  parameter int unsigned DIV_W     = 4,
  parameter int unsigned MAIN_LOG2 = 5,
  parameter int unsigned MID_LOG2  = 3,
  parameter int unsigned SUB_LOG2  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sub_tick_i,
  input  logic             sub_stable_i,
  input  logic             wr_en_i,
  input  logic             wr_allow_i,
  input  logic             wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             wait_req_i,
  input  logic             wake_i,
  output logic [REG_W-1:0] ctl0_o,
  output logic [REG_W-1:0] ctl1_o,
  output logic             wait_o,
  output logic             cpu_ce,
  output logic             f1_ce,
  output logic             f8_ce,
  output logic             f32_ce,
  output logic             fad_ce,
  output logic             fc32_ce
);
  localparam logic [DIV_W-1:0] FORCE_M1 = DIV_W'(7);

  logic             rst_q1_n, rst_q_n;
  ctl0_t            c0;
  ctl1_t            c1;
  logic             wait_q, stopped, main_run, per_run, div_tick;
  logic [DIV_W-1:0] req_m1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1_n <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_q1_n <= 1'b1;
      rst_q_n  <= rst_q1_n;
    end
  end

  cmc_regs u_regs (
    .clk(clk), .rst_n(rst_q_n), .wr_stb(wr_en_i && wr_allow_i),
    .wr_sel(wr_sel_i), .wr_data(wr_data_i), .sub_stable(sub_stable_i),
    .wait_req(wait_req_i), .wake(wake_i), .c0(c0), .c1(c1), .wait_q(wait_q)
  );

  always_comb begin
    if (c0.force8) req_m1 = FORCE_M1;
    else begin
      unique case (c1.div_sel)
        2'b00:   req_m1 = DIV_W'(0);
        2'b01:   req_m1 = DIV_W'(1);
        2'b10:   req_m1 = DIV_W'(3);
        default: req_m1 = DIV_W'(15);
      endcase
    end
  end

  assign stopped  = c1.all_stop;
  assign main_run = !stopped && !c0.main_off;
  assign per_run  = main_run && !(wait_q && c0.per_stop);

  cmc_divider #(.CNT_W(DIV_W), .RST_M1(7)) u_div (
    .clk(clk), .rst_n(rst_q_n), .run(main_run), .req_m1(req_m1), .tick(div_tick)
  );

  cmc_prescale #(.MAIN_LOG2(MAIN_LOG2), .MID_LOG2(MID_LOG2), .SUB_LOG2(SUB_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_q_n), .per_run(per_run), .sub_run(!stopped),
    .sub_tick(sub_tick_i), .f1(f1_ce), .fmid(f8_ce), .fmain(f32_ce), .fsub(fc32_ce)
  );

  always_comb begin
    if (stopped || wait_q) cpu_ce = 1'b0;
    else if (c0.sub_sel)   cpu_ce = sub_tick_i;
    else                   cpu_ce = div_tick;
  end

  assign fad_ce = f1_ce;
  assign ctl0_o = c0;
  assign ctl1_o = c1;
  assign wait_o = wait_q;
endmodule

// File: rtl/cmc_checker.sv
module cmc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sub_stable,
  input logic [7:0] ctl0,
  input logic [7:0] ctl1,
  input logic       wait_m,
  input logic       cpu_ce,
  input logic       f1_ce,
  input logic       f8_ce,
  input logic       f32_ce,
  input logic       fc32_ce
);
  p_stop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl1[0] |-> !(cpu_ce || f1_ce || f8_ce || f32_ce || fc32_ce));

  p_wait_cpu_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wait_m |-> !cpu_ce);

  p_sel_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl0[7]) |-> ($past(ctl0[4]) && $past(sub_stable)));

  p_stop_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl1[0]) |-> ctl0[3]);

  p_nested_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (f32_ce |-> f8_ce) and (f8_ce |-> f1_ce));
endmodule

bind clk_mode_ctrl cmc_checker chk_i (
  .clk(clk), .rst_n(rst_q_n), .sub_stable(sub_stable_i), .ctl0(ctl0_o),
  .ctl1(ctl1_o), .wait_m(wait_o), .cpu_ce(cpu_ce), .f1_ce(f1_ce),
  .f8_ce(f8_ce), .f32_ce(f32_ce), .fc32_ce(fc32_ce)
);

// File: tb/clk_mode_ctrl_tb.sv
`timescale 1ns/1ps
module clk_mode_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sub_tick, sub_stable, wr_en, wr_allow, wr_sel, wait_req, wake;
  logic [7:0] wr_data, ctl0, ctl1;
  logic wait_o, cpu_ce, f1_ce, f8_ce, f32_ce, fad_ce, fc32_ce;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  clk_mode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sub_tick_i(sub_tick), .sub_stable_i(sub_stable),
    .wr_en_i(wr_en), .wr_allow_i(wr_allow), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .wait_req_i(wait_req), .wake_i(wake), .ctl0_o(ctl0), .ctl1_o(ctl1),
    .wait_o(wait_o), .cpu_ce(cpu_ce), .f1_ce(f1_ce), .f8_ce(f8_ce),
    .f32_ce(f32_ce), .fad_ce(fad_ce), .fc32_ce(fc32_ce)
  );

  // sub-clock tick: one cycle high out of five, changed just after posedge
  initial begin
    int sc = 0;
    sub_tick = 1'b0;
    forever begin
      @(posedge clk); #1;
      sc = (sc == 4) ? 0 : sc + 1;
      sub_tick = (sc == 0);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input int w);
    case (w)
      0: return cpu_ce;
      1: return f8_ce;
      2: return f32_ce;
      default: return fc32_ce;
    endcase
  endfunction

  task automatic gap(input int w, output int g);
    int n = 0;
    do begin @(negedge clk); n++; end while (!sig(w) && n < 400);
    g = 0;
    do begin @(negedge clk); g++; end while (!sig(w) && g < 400);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d, input logic allow);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; wr_allow = allow;
    @(negedge clk);
    wr_en = 1'b0; wr_allow = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake = 1'b1; @(negedge clk); wake = 1'b0;
  endtask

  task automatic count_ones(input int w, input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (w == 4 ? f1_ce : sig(w)) c++;
    end
  endtask

  task automatic t_reset();
    chk("R1 ctl0", ctl0, 8'h48);
    chk("R1 ctl1", ctl1, 8'h20);
    chk("R1 wait", wait_o, 0);
  endtask

  task automatic t_divisors();
    int g;
    gap(0, g); gap(0, g); chk("R2 reset div8", g, 8);
    wr(1'b1, 8'hE0, 1'b1);                      // field = 11 but force8 still on
    gap(0, g); gap(0, g); chk("R2 force overrides field", g, 8);
    wr(1'b0, 8'h48 & 8'hBF, 1'b1);               // clear force8
    gap(0, g); gap(0, g); chk("R3 div16", g, 16);
    wr(1'b1, 8'h60, 1'b1);
    gap(0, g); gap(0, g); chk("R3 div2", g, 2);
    wr(1'b1, 8'hA0, 1'b1);
    gap(0, g); gap(0, g); chk("R3 div4", g, 4);
    wr(1'b1, 8'h20, 1'b1);
    gap(0, g); gap(0, g); chk("R3 div1", g, 1);
  endtask

  task automatic t_switch_mid();
    int g, n;
    wr(1'b1, 8'hE0, 1'b1);
    gap(0, g); chk("R4 div16 settled", g, 16);
    n = 0;
    do @(negedge clk); while (!cpu_ce);
    g = 0;
    do begin
      @(negedge clk); g++;
      if (g == 4) begin wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h20; wr_allow = 1'b1; end
      if (g == 5) begin wr_en = 1'b0; wr_allow = 1'b0; end
    end while (!cpu_ce && g < 100);
    chk("R4 old period kept", g, 16);
    n = 0;
    do begin @(negedge clk); n++; end while (!cpu_ce && n < 100);
    chk("R4 new period", n, 1);
  endtask

  task automatic t_protect();
    wr(1'b0, 8'hFF, 1'b0);
    chk("R5 ctl0 held", ctl0, 8'h08);
    wr(1'b1, 8'h01, 1'b0);
    chk("R5 ctl1 held", ctl1, 8'h20);
  endtask

  task automatic t_prescale();
    int g;
    gap(1, g); chk("R12 f8 period", g, 8);
    gap(2, g); chk("R12 f32 period", g, 32);
    gap(3, g); chk("R12 fc32 period", g, 160);
    @(negedge clk);
    chk("R12 f1 and fad", {f1_ce, fad_ce}, 2'b11);
  endtask

  task automatic t_stop_fast();
    int c;
    wr(1'b0, 8'h00, 1'b1);
    wr(1'b1, 8'h01, 1'b1);
    chk("R8 ctl0 after stop", ctl0, 8'h48);
    chk("R8 ctl1 after stop", ctl1, 8'h21);
    c = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (cpu_ce || f1_ce || f8_ce || f32_ce || fad_ce || fc32_ce) c++;
    end
    chk("R8 enables quiet", c, 0);
    pulse_wake();
    chk("R10 stop cleared", ctl1, 8'h20);
  endtask

  task automatic t_sub_select();
    int c;
    sub_stable = 1'b1;
    wr(1'b0, 8'h80, 1'b1);
    chk("R6 refused, enable clear", ctl0, 8'h00);
    sub_stable = 1'b0;
    wr(1'b0, 8'h10, 1'b1);
    wr(1'b0, 8'h90, 1'b1);
    chk("R6 refused, not stable", ctl0, 8'h10);
    sub_stable = 1'b1;
    wr(1'b0, 8'h90, 1'b1);
    chk("R6 accepted", ctl0, 8'h90);
    c = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cpu_ce != sub_tick) c++;
    end
    chk("R7 cpu follows sub tick", c, 0);
    wr(1'b0, 8'hB0, 1'b1);
    c = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cpu_ce != sub_tick || f1_ce || f8_ce || f32_ce || fad_ce) c++;
    end
    chk("R7 low power", c, 0);
    wr(1'b0, 8'h90, 1'b1);
  endtask

  task automatic t_stop_slow();
    wr(1'b1, 8'h00, 1'b1);
    wr(1'b1, 8'h01, 1'b1);
    chk("R9 ctl0 retained", ctl0, 8'h98);
    chk("R9 ctl1 retained", ctl1, 8'h01);
    pulse_wake();
    chk("R10 stop cleared slow", ctl1, 8'h00);
    wr(1'b0, 8'h10, 1'b1);
  endtask

  task automatic t_wait();
    int c, g;
    wr(1'b0, 8'h08, 1'b1);
    @(negedge clk); wait_req = 1'b1; @(negedge clk); wait_req = 1'b0;
    chk("R11 wait set", wait_o, 1);
    count_ones(0, 40, c); chk("R11 cpu off", c, 0);
    count_ones(1, 64, c); chk("R11 f8 runs", c, 8);
    pulse_wake();
    chk("R10 wait cleared", wait_o, 0);
    wr(1'b0, 8'h0C, 1'b1);
    @(negedge clk); wait_req = 1'b1; @(negedge clk); wait_req = 1'b0;
    count_ones(4, 40, c); chk("R11 f1 gated", c, 0);
    gap(3, g); chk("R11 fc32 runs", g, 160);
    pulse_wake();
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    sub_stable = 1'b0; wr_en = 1'b0; wr_allow = 1'b0; wr_sel = 1'b0;
    wr_data = 8'h00; wait_req = 1'b0; wake = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_divisors();
    t_switch_mid();
    t_protect();
    t_prescale();
    t_stop_fast();
    t_sub_select();
    t_stop_slow();
    t_wait();
    finish_run();
  end
endmodule